// File: doc/BRIEF.md
# ECC-Protected Half-Line Store with Raw Diagnostic Staging

This block is the data array of a cache, with no tags and no replacement logic. Each entry holds a 32-byte half-line as two 16-byte chunks. Each chunk carries its own 9-bit SEC-DED code. A normal write stores one chunk and always computes fresh check bits for it. A normal read returns one chunk after a single-bit error has been corrected. Along with the data it gives the syndrome and two status flags: correctable and uncorrectable.

A second path exists for fault injection and post-mortem inspection. It uses five staging registers: four 64-bit data registers and one register that holds both 9-bit check fields. A diagnostic load copies a whole entry into the staging registers, with all 256 data bits and 18 check bits, without decoding. A diagnostic store writes the staging registers back into the entry without encoding. Two host commands move one staging register to or from a 64-bit host port. Software can therefore load an entry, flip any mix of data and check bits, store it back, and then read it through the normal path to exercise the corrector.

Top module: `ecc_stage_array`

## Requirements
- R1: After reset, every staging register reads zero, `rd_valid`, `rd_ce` and `rd_ue` are low, and `host_rdata` is zero.
- R2: A normal read (`op_code`=2) raises `rd_valid` in the cycle after the command. When the stored chunk is intact, `rd_data` equals the data last written, `rd_syndrome` is 0, and both flags are low.
- R3: A normal write (`op_code`=1) stores `wdata` into chunk `chunk_sel` (0 = bits 127:0 of the entry, 1 = bits 255:128) with freshly computed check bits. Data bit i sits at the i-th position, counted from 3 upward, among the positions in 1..255 that are not powers of two. Check bit j (j<8) is the XOR of the data bits whose position has bit j set. Check bit 8 is the even parity of the 128 data bits and check bits 7:0.
- R4: The 9-bit syndrome has two parts. Bits 7:0 are the recomputed bits 7:0 XOR the stored bits 7:0. Bit 8 is the XOR of all 128 data bits and all 9 stored check bits.
- R5: If exactly one data bit or check bit of a chunk is flipped, the read sets `rd_ce`, clears `rd_ue`, and returns the original data.
- R6: If the syndrome is nonzero and no single-bit flip explains it (for example, two flipped bits), the read sets `rd_ue`, clears `rd_ce`, and returns the stored data unchanged.
- R7: A diagnostic load (`op_code`=3) copies the entry raw into staging. Data register k (k=0..3) receives entry bits 64k+63:64k. The check register receives chunk 0's code in bits 8:0 and chunk 1's code in bits 17:9.
- R8: A diagnostic store (`op_code`=4) writes the staging registers into the entry in the same layout, with no encoding. A later normal read sees exactly those bits.
- R9: A host put (`op_code`=5) writes `host_wdata` into the staging register chosen by `stg_idx`: 0..3 select the data registers, and 4 selects the check register (bits 17:0). A host get (`op_code`=6) returns that register on `host_rdata` in the next cycle, with the check register zero-extended.
- R10: `stg_idx` values 5..7 are ignored: a host put to them changes no staging register, and a host get from them returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Command strobe |
| op_code | input | 3 | 1 write, 2 read, 3 diag load, 4 diag store, 5 host put, 6 host get |
| addr | input | AW | Entry index |
| chunk_sel | input | 1 | Chunk for normal access |
| wdata | input | 128 | Normal write data |
| stg_idx | input | 3 | Staging register select |
| host_wdata | input | 64 | Host put data |
| rd_valid | output | 1 | Normal read result valid |
| rd_data | output | 128 | Corrected (or passed-through) read data |
| rd_syndrome | output | 9 | Read syndrome |
| rd_ce | output | 1 | Correctable error flag |
| rd_ue | output | 1 | Uncorrectable error flag |
| host_rdata | output | 64 | Staging register read value |

## Verification
The embedded properties check, every cycle, that the two error flags are never set together and that a zero syndrome raises neither flag. They also check that `rd_valid` follows only a read command and that a host access at index 5..7 leaves staging untouched and returns zero. Whether correction restores the right bit, whether the check bits follow the stated code, and whether the raw load and store layouts match can only be shown by the bench scenarios. These scenarios corrupt entries through staging and compare each read against a brute-force reference decoder.

// File: rtl/ecc_stage_array.sv
module ecc_stage_array #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [AW-1:0] addr,
  input  logic          chunk_sel,
  input  logic [127:0]  wdata,
  input  logic [2:0]    stg_idx,
  input  logic [63:0]   host_wdata,
  output logic          rd_valid,
  output logic [127:0]  rd_data,
  output logic [8:0]    rd_syndrome,
  output logic          rd_ce,
  output logic          rd_ue,
  output logic [63:0]   host_rdata
);
  localparam logic [2:0] OP_WR = 3'd1, OP_RD = 3'd2, OP_DLD = 3'd3,
                         OP_DST = 3'd4, OP_PUT = 3'd5, OP_GET = 3'd6;

  function automatic logic [8:0] ecc_gen(input logic [127:0] d);
    logic [8:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p < 256; p++)
      if (((p & (p - 1)) != 0) && k < 128) begin
        if (d[k]) c[7:0] ^= p[7:0];
        k++;
      end
    c[8] = ^d ^ ^c[7:0];
    return c;
  endfunction

  logic [255:0] mem_d [DEPTH];
  logic [17:0]  mem_c [DEPTH];
  logic [63:0]  stg [4];
  logic [17:0]  stg_c;
  logic [127:0] rd_raw;
  logic [8:0]   rd_ck;

  wire cmd_wr  = op_valid && op_code == OP_WR;
  wire cmd_rd  = op_valid && op_code == OP_RD;
  wire cmd_dld = op_valid && op_code == OP_DLD;
  wire cmd_dst = op_valid && op_code == OP_DST;
  wire cmd_put = op_valid && op_code == OP_PUT;
  wire cmd_get = op_valid && op_code == OP_GET;

  always_ff @(posedge clk) begin
    if (cmd_wr) begin
      mem_d[addr][chunk_sel*128 +: 128] <= wdata;
      mem_c[addr][chunk_sel*9 +: 9]     <= ecc_gen(wdata);
    end else if (cmd_dst) begin
      mem_d[addr] <= {stg[3], stg[2], stg[1], stg[0]};
      mem_c[addr] <= stg_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) stg[i] <= '0;
      stg_c      <= '0;
      host_rdata <= '0;
      rd_valid   <= 1'b0;
      rd_raw     <= '0;
      rd_ck      <= '0;
    end else begin
      rd_valid <= cmd_rd;
      if (cmd_rd) begin
        rd_raw <= mem_d[addr][chunk_sel*128 +: 128];
        rd_ck  <= mem_c[addr][chunk_sel*9 +: 9];
      end
      if (cmd_dld) begin
        for (int i = 0; i < 4; i++) stg[i] <= mem_d[addr][i*64 +: 64];
        stg_c <= mem_c[addr];
      end else if (cmd_put) begin
        if (stg_idx < 3'd4) stg[stg_idx[1:0]] <= host_wdata;
        else if (stg_idx == 3'd4) stg_c <= host_wdata[17:0];
      end
      if (cmd_get)
        host_rdata <= (stg_idx < 3'd4) ? stg[stg_idx[1:0]] :
                      (stg_idx == 3'd4) ? {46'd0, stg_c} : 64'd0;
    end
  end

  wire [8:0] rd_gen = ecc_gen(rd_raw);
  assign rd_syndrome = {^rd_raw ^ ^rd_ck, rd_gen[7:0] ^ rd_ck[7:0]};

  logic [127:0] fixed;
  logic         hit;
  always_comb begin
    int k;
    fixed = rd_raw;
    hit   = 1'b0;
    k     = 0;
    for (int p = 1; p < 256; p++)
      if (((p & (p - 1)) != 0) && k < 128) begin
        if (p[7:0] == rd_syndrome[7:0]) begin
          fixed[k] = ~fixed[k];
          hit = 1'b1;
        end
        k++;
      end
  end

  wire single = rd_syndrome[8] && (hit || $onehot0(rd_syndrome[7:0]));
  assign rd_ce   = rd_valid && single;
  assign rd_ue   = rd_valid && rd_syndrome != 9'd0 && !single;
  assign rd_data = single ? fixed : rd_raw;

  wire [273:0] stg_all = {stg_c, stg[3], stg[2], stg[1], stg[0]};

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ce && rd_ue));
  assert_clean_no_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_syndrome == 9'd0) |-> (!rd_ce && !rd_ue));
  assert_valid_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd |=> rd_valid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_rd) |=> !rd_valid);
  assert_bad_idx_put_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_put && stg_idx > 3'd4) |=> $stable(stg_all));
  assert_bad_idx_get_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_get && stg_idx > 3'd4) |=> host_rdata == 64'd0);
endmodule

// File: tb/sim_ecc_stage_array.sv
module sim_ecc_stage_array;
  localparam int PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, op_valid = 0, chunk_sel = 0;
  logic [2:0] op_code = 0, stg_idx = 0;
  logic [AW-1:0] addr = 0;
  logic [127:0] wdata = 0;
  logic [63:0] host_wdata = 0;
  logic rd_valid, rd_ce, rd_ue;
  logic [127:0] rd_data;
  logic [8:0] rd_syndrome;
  logic [63:0] host_rdata;

  ecc_stage_array #(.DEPTH(DEPTH)) u0 (.clk, .rst_n, .op_valid, .op_code, .addr,
    .chunk_sel, .wdata, .stg_idx, .host_wdata, .rd_valid, .rd_data, .rd_syndrome,
    .rd_ce, .rd_ue, .host_rdata);

  always #(PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  logic [255:0] m_d [DEPTH];
  logic [17:0]  m_c [DEPTH];
  logic [63:0]  m_s [5];

  function automatic logic [8:0] b_gen(input logic [127:0] d);
    logic [8:0] c;
    int p;
    c = '0;
    p = 3;
    for (int i = 0; i < 128; i++) begin
      while ((p & (p - 1)) == 0) p++;
      if (d[i]) c[7:0] ^= p[7:0];
      p++;
    end
    c[8] = ^{d, c[7:0]};
    return c;
  endfunction

  function automatic logic [8:0] b_syn(input logic [127:0] d, input logic [8:0] c);
    logic [8:0] g;
    g = b_gen(d);
    return {^{d, c}, g[7:0] ^ c[7:0]};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] code, input int a, input logic ch,
                       input logic [127:0] wd, input logic [2:0] idx, input logic [63:0] hw);
    @(negedge clk);
    op_valid = 1; op_code = code; addr = AW'(a); chunk_sel = ch;
    wdata = wd; stg_idx = idx; host_wdata = hw;
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic nwrite(input int a, input logic ch, input logic [127:0] d);
    issue(3'd1, a, ch, d, 0, 0);
    m_d[a][ch*128 +: 128] = d;
    m_c[a][ch*9 +: 9] = b_gen(d);
  endtask

  task automatic nread(input int a, input logic ch, input string tag);
    logic [127:0] d, ed;
    logic [8:0] c, s;
    logic ce, ue;
    d = m_d[a][ch*128 +: 128];
    c = m_c[a][ch*9 +: 9];
    s = b_syn(d, c);
    ce = 0; ed = d;
    if (s != 0)
      for (int j = 0; j < 137; j++) begin
        logic [127:0] d2;
        logic [8:0] c2;
        d2 = d; c2 = c;
        if (j < 128) d2[j] = ~d2[j]; else c2[j-128] = ~c2[j-128];
        if (b_syn(d2, c2) == 0) begin ce = 1; ed = d2; end
      end
    ue = (s != 0) && !ce;
    issue(3'd2, a, ch, 0, 0, 0);
    chk({tag, " rd_valid R2"}, 128'(rd_valid), 128'(1));
    chk({tag, " syndrome R4"}, 128'(rd_syndrome), 128'(s));
    chk({tag, " ce R5"}, 128'(rd_ce), 128'(ce));
    chk({tag, " ue R6"}, 128'(rd_ue), 128'(ue));
    chk({tag, " data R5/R6"}, rd_data, ed);
  endtask

  task automatic dload(input int a);
    issue(3'd3, a, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) m_s[k] = m_d[a][k*64 +: 64];
    m_s[4] = {46'd0, m_c[a]};
  endtask

  task automatic dstore(input int a);
    issue(3'd4, a, 0, 0, 0, 0);
    m_d[a] = {m_s[3], m_s[2], m_s[1], m_s[0]};
    m_c[a] = m_s[4][17:0];
  endtask

  task automatic put(input logic [2:0] idx, input logic [63:0] v);
    issue(3'd5, 0, 0, 0, idx, v);
    if (idx < 4) m_s[idx] = v;
    else if (idx == 4) m_s[4] = {46'd0, v[17:0]};
  endtask

  task automatic get(input logic [2:0] idx, input string tag);
    issue(3'd6, 0, 0, 0, idx, 0);
    chk(tag, 128'(host_rdata), (idx <= 4) ? 128'(m_s[idx]) : 128'd0);
  endtask

  task automatic flip_data(input int a, input int bitn);
    dload(a);
    put(3'(bitn / 64), m_s[bitn / 64] ^ (64'd1 << (bitn % 64)));
    dstore(a);
  endtask

  task automatic flip_check(input int a, input int bitn);
    dload(a);
    put(3'd4, m_s[4] ^ (64'd1 << bitn));
    dstore(a);
  endtask

  initial begin
    #(PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int k = 0; k < 5; k++) m_s[k] = 0;
    #(PERIOD * 3);
    @(negedge clk);
    chk("reset rd_valid R1", 128'(rd_valid), 0);
    chk("reset flags R1", 128'({rd_ce, rd_ue}), 0);
    chk("reset host_rdata R1", 128'(host_rdata), 0);
    rst_n = 1;
    for (int k = 0; k < 5; k++) get(3'(k), "reset staging R1");

    for (int a = 0; a < DEPTH; a++)
      for (int ch = 0; ch < 2; ch++)
        nwrite(a, ch[0], {$urandom, $urandom, $urandom, $urandom});

    nwrite(1, 0, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210);
    nread(1, 0, "clean R2");
    nwrite(2, 1, '0);
    nread(2, 1, "zero data R2");
    nwrite(2, 0, '1);
    nread(2, 0, "ones data R2");

    dload(1);
    get(3'd4, "fresh check bits R3 R7");
    get(3'd0, "diag load low word R7");
    get(3'd3, "diag load high word R7");

    flip_data(3, 0);    nread(3, 0, "flip data bit0 R5");
    flip_data(3, 255);  nread(3, 1, "flip data bit127 chunk1 R5");
    flip_check(4, 2);   nread(4, 0, "flip check bit R5");
    flip_check(4, 17);  nread(4, 1, "flip parity bit R5");
    flip_data(5, 7); flip_data(5, 90); nread(5, 0, "double data R6");
    flip_data(6, 130); flip_check(6, 12); nread(6, 1, "data plus check R6");
    flip_check(7, 0); flip_check(7, 1); nread(7, 0, "double check R6");

    put(3'd2, 64'hdead_beef_cafe_f00d);
    dstore(8);
    dload(8);
    get(3'd2, "store then load raw R8");
    nread(8, 1, "raw stored chunk R8");

    put(3'd1, 64'h1111_2222_3333_4444);
    put(3'd5, 64'hffff_ffff_ffff_ffff);
    put(3'd7, 64'h5555_aaaa_5555_aaaa);
    for (int k = 0; k < 5; k++) get(3'(k), "bad index put ignored R10");
    get(3'd6, "bad index get zero R10");
    get(3'd5, "bad index get zero R10");
    put(3'd4, 64'hffff_ffff_ffff_ffff);
    get(3'd4, "check reg width R9");

    for (int n = 0; n < 300; n++) begin
      int a, sel;
      a = $urandom % DEPTH;
      sel = $urandom % 8;
      case (sel)
        0: nwrite(a, 1'($urandom), {$urandom, $urandom, $urandom, $urandom});
        1, 2: nread(a, 1'($urandom), "random read R2 R5 R6");
        3: dload(a);
        4: dstore(a);
        5: put(3'($urandom), {$urandom, $urandom});
        6: get(3'($urandom), "random get R9 R10");
        default: begin
          flip_data(a, $urandom % 256);
          nread(a, 1'($urandom), "random single flip R5");
        end
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule